// File: doc/BRIEF.md
# Negative-Slope Stochastic Piecewise-Linear Function Evaluator

This block evaluates one of two decreasing functions of an 8-bit fraction x in [0,1): the exponential e^-x or the cosine cos(x). Each function is approximated by a straight line per segment of the input range, and the three top bits of x pick the segment. The slope multiplication is done in the stochastic domain. Two linear-feedback shift registers each drive a comparator, one for x and one for the slope magnitude. One of the two bits is chosen for each cycle: the AND of the two bits, or in cosine mode their NAND. A ones-counter collects the chosen bit over 256 cycles. The offset is then applied as a binary subtraction in exponential mode and as a binary addition in cosine mode.

Every slope of both curves is negative, yet the stored slopes carry no sign. In exponential mode the product of x and the slope magnitude is subtracted from the offset. In cosine mode the NAND gives 1 − |a|·x directly. The stored offset is then the true offset less one, and it is added back. The caller pulses start with x and the mode held on the same edge. After a fixed latency, done pulses for one cycle and the 9-bit result (units of 2^-8) is valid. The result holds until the next conversion completes.

Top module: `npwl_eval`

## Requirements
- R1: While rst_n is low, and from reset release until the first conversion completes, result is 0 and done is 0.
- R2: The segment index is x[7:5]. In exponential mode (mode_cos = 0) the slope magnitudes for segments 0..7 are 234, 211, 187, 166, 144, 131, 116, 101, and the offsets are 256, 252, 246, 238, 227, 219, 208, 195. In cosine mode (mode_cos = 1) the slope magnitudes are 13, 47, 79, 106, 138, 162, 186, 211, and the stored offsets are 0, 4, 12, 22, 38, 53, 71, 93. Each stored cosine offset is the true offset less 256.
- R3: Each conversion takes 256 samples k = 0..255. Sample k uses the state of each LFSR after k steps from its seed. The x register has seed 0xA5 and steps as s ← {s[6:0], s[7]^s[0]}. The slope register has seed 0x3C and steps as s ← {s[6:0], s[7]^s[1]}. The x bit is 1 when the x register is below x, and the slope bit is 1 when the slope register is below the slope magnitude. Both registers reseed at every conversion.
- R4: In exponential mode, let N be the number of samples in which both bits are 1. The result is offset − N, clamped at 0.
- R5: In cosine mode, let M be the number of samples in which the NAND of the two bits is 1. The result is stored offset + M, clamped at 511.
- R6: Number the rising edge that accepts start as edge 1. Done is high for exactly the one cycle that follows edge 258, and the new result appears in that same cycle.
- R7: start is accepted only when no conversion is in progress. A start, x or mode_cos change during a conversion has no effect on that conversion's result or timing.
- R8: Outside the done cycle, result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| x_in | input | 8 | Input fraction x in units of 2^-8 |
| mode_cos | input | 1 | 0 selects e^-x, 1 selects cos(x) |
| result | output | 9 | Function value in units of 2^-8 |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
The bench sweeps every input code in both modes, which reaches all eight segments and their boundary codes. These include x = 0, where the x stream is all zeros: the product count must be 0 in exponential mode and all 256 samples must count in cosine mode. A design that used the wrong stream bit, applied the offset with the wrong sign, or did not reseed the registers would give wrong results across whole segments. An off-by-one in the sample counter would move done away from edge 258 and shift every count. A start or input change injected mid-conversion must leave the running result untouched; a design that re-latched its inputs would return the value for the injected code.

// File: rtl/npwl_pkg.sv
package npwl_pkg;
  localparam int unsigned COEF_W = 8;
  localparam int unsigned OFFS_W = 9;
  localparam int unsigned SEG_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } npwl_state_e;
endpackage

// File: rtl/npwl_coef_rom.sv
module npwl_coef_rom
  import npwl_pkg::*;
(
  input  logic [SEG_W-1:0]  seg,
  input  logic              cos_sel,
  output logic [COEF_W-1:0] slope_mag,
  output logic [OFFS_W-1:0] offset
);
  always_comb begin
    slope_mag = '0;
    offset    = '0;
    case ({cos_sel, seg})
      4'h0: begin slope_mag = 8'd234; offset = 9'd256; end
      4'h1: begin slope_mag = 8'd211; offset = 9'd252; end
      4'h2: begin slope_mag = 8'd187; offset = 9'd246; end
      4'h3: begin slope_mag = 8'd166; offset = 9'd238; end
      4'h4: begin slope_mag = 8'd144; offset = 9'd227; end
      4'h5: begin slope_mag = 8'd131; offset = 9'd219; end
      4'h6: begin slope_mag = 8'd116; offset = 9'd208; end
      4'h7: begin slope_mag = 8'd101; offset = 9'd195; end
      4'h8: begin slope_mag = 8'd13;  offset = 9'd0;   end
      4'h9: begin slope_mag = 8'd47;  offset = 9'd4;   end
      4'hA: begin slope_mag = 8'd79;  offset = 9'd12;  end
      4'hB: begin slope_mag = 8'd106; offset = 9'd22;  end
      4'hC: begin slope_mag = 8'd138; offset = 9'd38;  end
      4'hD: begin slope_mag = 8'd162; offset = 9'd53;  end
      4'hE: begin slope_mag = 8'd186; offset = 9'd71;  end
      default: begin slope_mag = 8'd211; offset = 9'd93; end
    endcase
  end
endmodule

// File: rtl/npwl_sng.sv
module npwl_sng #(
  parameter int unsigned  W    = 8,
  parameter int unsigned  TAP  = 0,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] level,
  output logic         bit_o
);
  logic [W-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (load)     lfsr_d = SEED;
    else if (adv) lfsr_d = {lfsr_q[W-2:0], lfsr_q[W-1] ^ lfsr_q[TAP]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign bit_o = (lfsr_q < level);
endmodule

// File: rtl/npwl_ones_acc.sv
module npwl_ones_acc #(
  parameter int unsigned CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_i,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = count;
    if (clr)              cnt_d = '0;
    else if (en && bit_i) cnt_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= cnt_d;
  end
endmodule

// File: rtl/npwl_eval.sv
module npwl_eval
  import npwl_pkg::*;
#(
  parameter int unsigned XW     = 8,
  parameter logic [7:0]  SEED_X = 8'hA5,
  parameter logic [7:0]  SEED_A = 8'h3C,
  parameter int unsigned TAP_X  = 0,
  parameter int unsigned TAP_A  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [XW-1:0] x_in,
  input  logic          mode_cos,
  output logic [XW:0]   result,
  output logic          done
);
  localparam int unsigned RW   = XW + 1;
  localparam logic [RW:0] RMAX = {1'b0, {RW{1'b1}}};

  npwl_state_e state_q, state_d;
  logic load, run, fin, busy;
  logic [XW-1:0]     cyc_q;
  logic [XW-1:0]     x_q;
  logic              mode_q;
  logic [COEF_W-1:0] a_q, rom_a;
  logic [OFFS_W-1:0] b_q, rom_b;
  logic              xb, ab, sel_bit;
  logic [RW-1:0]     ones;
  logic [RW-1:0]     res_d;
  logic [RW:0]       sum;

  always_comb begin
    state_d = state_q;
    load = 1'b0;
    run  = 1'b0;
    fin  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin load = 1'b1; state_d = ST_RUN; end
      ST_RUN: begin
        run = 1'b1;
        if (cyc_q == '1) state_d = ST_FIN;
      end
      ST_FIN: begin fin = 1'b1; state_d = ST_IDLE; end
      default: state_d = ST_IDLE;
    endcase
  end
  assign busy = (state_q != ST_IDLE);

  npwl_coef_rom u_rom (
    .seg(x_in[XW-1 -: SEG_W]), .cos_sel(mode_cos),
    .slope_mag(rom_a), .offset(rom_b)
  );

  npwl_sng #(.W(XW), .TAP(TAP_X), .SEED(SEED_X)) u_sng_x (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(run), .level(x_q), .bit_o(xb)
  );
  npwl_sng #(.W(COEF_W), .TAP(TAP_A), .SEED(SEED_A)) u_sng_a (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(run), .level(a_q), .bit_o(ab)
  );

  assign sel_bit = mode_q ? ~(xb & ab) : (xb & ab);

  npwl_ones_acc #(.CW(RW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(run), .bit_i(sel_bit), .count(ones)
  );

  always_comb begin
    sum = {1'b0, b_q} + {1'b0, ones};
    if (mode_q) res_d = (sum > RMAX) ? RMAX[RW-1:0] : sum[RW-1:0];
    else        res_d = (b_q >= ones) ? (b_q - ones) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      x_q     <= '0;
      mode_q  <= 1'b0;
      a_q     <= '0;
      b_q     <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= fin;
      if (load) begin
        x_q    <= x_in;
        mode_q <= mode_cos;
        a_q    <= rom_a;
        b_q    <= rom_b;
        cyc_q  <= '0;
      end else if (run) begin
        cyc_q  <= cyc_q + 1'b1;
      end
      if (fin) result <= res_d;
    end
  end
endmodule

// File: rtl/npwl_eval_chk.sv
module npwl_eval_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [8:0] result,
  input logic       busy,
  input logic       mode_q,
  input logic [8:0] ones
);
  logic [9:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since <= '0;
    else if (start && !busy)    since <= 10'd1;
    else if (done)              since <= '0;
    else if (since != 10'd0)    since <= since + 10'd1;
  end

  a_r6_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since == 10'd258));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
  a_r4_exp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (result <= 9'd256));
  a_r3_ones_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ones <= 9'd256));
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind npwl_eval npwl_eval_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
  .busy(busy), .mode_q(mode_q), .ones(ones)
);

// File: tb/npwl_eval_test.sv
module npwl_eval_test;
  logic       clk, rst_n, start, mode_cos;
  logic [7:0] x_in;
  logic [8:0] result;
  logic       done;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  npwl_eval uut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
    .mode_cos(mode_cos), .result(result), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int coef_a(input bit m, input int seg);
    int ea[8] = '{234, 211, 187, 166, 144, 131, 116, 101};
    int ca[8] = '{13, 47, 79, 106, 138, 162, 186, 211};
    return m ? ca[seg] : ea[seg];
  endfunction

  function automatic int coef_b(input bit m, input int seg);
    int eb[8] = '{256, 252, 246, 238, 227, 219, 208, 195};
    int cb[8] = '{0, 4, 12, 22, 38, 53, 71, 93};
    return m ? cb[seg] : eb[seg];
  endfunction

  // R2 R3 R4 R5: arithmetic model of one conversion
  function automatic int model(input int xv, input bit m);
    int seg = xv / 32;
    int a = coef_a(m, seg);
    int b = coef_b(m, seg);
    logic [7:0] sx = 8'hA5;
    logic [7:0] sa = 8'h3C;
    int n = 0;
    for (int k = 0; k < 256; k++) begin
      bit xb = (int'(sx) < xv);
      bit ab = (int'(sa) < a);
      bit p = xb & ab;
      if (m ? !p : p) n++;
      sx = {sx[6:0], sx[7] ^ sx[0]};
      sa = {sa[6:0], sa[7] ^ sa[1]};
    end
    if (m) return (b + n > 511) ? 511 : b + n;
    return (b - n < 0) ? 0 : b - n;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int xv, input bit m, output int r, output int lat);
    @(negedge clk);
    start = 1'b1; x_in = 8'(xv); mode_cos = m;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    r = int'(result);
  endtask

  initial begin
    int r, lat;
    rst_n = 1'b0; start = 1'b0; x_in = '0; mode_cos = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset result", int'(result), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle result", int'(result), 0);

    // R4 R5 R6: exhaustive sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int xv = 0; xv < 256; xv++) begin
        convert(xv, bit'(m), r, lat);
        check(m ? "R5 cos result" : "R4 exp result", r, model(xv, bit'(m)));
        check("R6 latency", lat, 258);
      end
    end

    // R6 R8: done is a pulse and result holds afterwards
    convert(8'h9C, 1'b0, r, lat);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
    repeat (5) @(negedge clk);
    check("R8 result hold", int'(result), model(8'h9C, 1'b0));

    // R7: start, x and mode changes during a conversion are ignored
    @(negedge clk);
    start = 1'b1; x_in = 8'h40; mode_cos = 1'b0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (10) begin @(negedge clk); lat++; end
    start = 1'b1; x_in = 8'hFF; mode_cos = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0; x_in = 8'h07;
    while (!done && lat < 400) begin @(negedge clk); lat++; end
    check("R7 busy start ignored result", int'(result), model(8'h40, 1'b0));
    check("R7 busy start latency", lat, 258);
    repeat (300) @(negedge clk);
    check("R7 no second conversion", int'(result), model(8'h40, 1'b0));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule